// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a two-port memory. A left port and a right port share one array of 9-bit words. Each port has its own clock and its own pair of chip selects. Each port also has a write/read select, a data-output drive enable and an address path. The address path either takes an external address or follows a private burst counter. The counter can be loaded from the address pins, stepped by one, cleared to zero, or left holding. Strict priority decides between these actions: clear first, then load, then step. This lets a port stream through consecutive words without presenting a new address every cycle.

A per-port mode pin picks the read latency. In short mode, read data leaves a single register. In long mode, it passes through a second output register to allow a higher clock rate. The pad driver is modelled as a data bus plus a valid flag, and the bus reads as zero whenever the flag is low.

If both ports write one word on the same clock edge, the left port's data is kept. This collision rule assumes both ports run on a common clock. The address width is a parameter: 16 gives the full 64K-word array, and the default is kept small.

Top module: `dual_burst_ram`

## Requirements
- R1: A port acts only when its `sel0_n` input is 0 and its `sel1` input is 1 together. With any other combination that port neither writes the array nor raises `dout_vld`.
- R2: A selected port with `wr_n` = 0 writes `din` into the word it addresses. A selected port with `wr_n` = 1 reads that word.
- R3: With `strobe_n` = 0 (and `zero_n` = 1), the access uses the `addr` input, and the burst counter is loaded with that address.
- R4: With `step_n` = 0 and both `strobe_n` and `zero_n` at 1, the access uses the counter value plus one, and the counter takes that value. The all-ones address steps to zero.
- R5: `step_n` has no effect in any cycle where `strobe_n` or `zero_n` is 0.
- R6: With `zero_n` = 0, the access uses address 0 and the counter becomes 0, whatever `strobe_n` and `step_n` are.
- R7: With `strobe_n`, `step_n` and `zero_n` all at 1, the counter holds, and the access uses the held value.
- R8: With `pipe` = 0, read data and `dout_vld` appear just after the clock edge that samples the read, for one cycle.
- R9: With `pipe` = 1, read data and `dout_vld` appear one clock later than in R8, for one cycle.
- R10: With `drive_n` = 1, `dout_vld` is 0 and `dout` is 0, even when read data is due.
- R11: When both ports write the same address on the same edge, the left port's data is what is stored.
- R12: A word written through either port is read back by the other port.
- R13: During and after the asynchronous reset, both `dout_vld` outputs are 0 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous reset, active low |
| l_clk | input | 1 | Left port clock |
| l_sel0_n | input | 1 | Left select, active low |
| l_sel1 | input | 1 | Left select, active high |
| l_wr_n | input | 1 | Left: 0 = write, 1 = read |
| l_drive_n | input | 1 | Left output drive enable, active low |
| l_strobe_n | input | 1 | Left: use and load external address |
| l_step_n | input | 1 | Left: step burst counter |
| l_zero_n | input | 1 | Left: clear burst counter |
| l_pipe | input | 1 | Left read latency: 0 short, 1 long |
| l_addr | input | AW | Left external address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left read data |
| l_dout_vld | output | 1 | Left read data valid and driven |
| r_clk | input | 1 | Right port clock |
| r_sel0_n | input | 1 | Right select, active low |
| r_sel1 | input | 1 | Right select, active high |
| r_wr_n | input | 1 | Right: 0 = write, 1 = read |
| r_drive_n | input | 1 | Right output drive enable, active low |
| r_strobe_n | input | 1 | Right: use and load external address |
| r_step_n | input | 1 | Right: step burst counter |
| r_zero_n | input | 1 | Right: clear burst counter |
| r_pipe | input | 1 | Right read latency: 0 short, 1 long |
| r_addr | input | AW | Right external address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right read data |
| r_dout_vld | output | 1 | Right read data valid and driven |

## Verification
The stimulus covers the following cases:
- The left port fills a region with address-dependent data. The right port then bursts through it, which separates a counter that steps from one that only reloads or holds.
- Some cycles combine clear, load and step in conflicting ways. Any priority mistake then shows up as a read of the wrong, distinctly valued word.
- A load of the top address followed by a step shows whether the counter wraps.
- The same read sequence is repeated in both latency modes, to catch a one-cycle timing error.
- Deselected writes, reads with the drive enable withdrawn, and a same-address double write test selection, output gating and the left-wins rule. In each case a later read returns either the old or the surviving value.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;
   localparam int NUM_PORTS = 2;
   localparam int LEFT      = 0;
   localparam int RIGHT     = 1;

   typedef enum logic {
      LAT_SHORT = 1'b0,
      LAT_LONG  = 1'b1
   } rd_lat_e;

   function automatic logic port_active(input logic sel0_n, input logic sel1);
      return (!sel0_n) && sel1;
   endfunction
endpackage

// File: rtl/dbr_burst_ctr.sv
`timescale 1ns/1ps
module dbr_burst_ctr #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic          strobe_n,
   input  logic          step_n,
   input  logic          zero_n,
   output logic [AW-1:0] acc_addr
);
   logic [AW-1:0] cnt_q;
   logic [AW-1:0] cnt_nxt;

   // priority: clear, then load, then step, then hold
   always_comb begin
      if (!zero_n)        cnt_nxt = '0;
      else if (!strobe_n) cnt_nxt = ext_addr;
      else if (!step_n)   cnt_nxt = cnt_q + AW'(1);
      else                cnt_nxt = cnt_q;
   end

   assign acc_addr = cnt_nxt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) cnt_q <= '0;
      else         cnt_q <= cnt_nxt;
   end

   p_clear_wins_r6: assert property (@(posedge clk) disable iff (!arst_n)
      !zero_n |=> (cnt_q == '0));
   p_load_r3: assert property (@(posedge clk) disable iff (!arst_n)
      (zero_n && !strobe_n) |=> (cnt_q == $past(ext_addr)));
   p_step_masked_r5: assert property (@(posedge clk) disable iff (!arst_n)
      (zero_n && !strobe_n && !step_n) |=> (cnt_q == $past(ext_addr)));
   p_step_wrap_r4: assert property (@(posedge clk) disable iff (!arst_n)
      (zero_n && strobe_n && !step_n) |=> (cnt_q == $past(cnt_q) + AW'(1)));
   p_hold_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (zero_n && strobe_n && step_n) |=> $stable(cnt_q));
endmodule

// File: rtl/dbr_read_stage.sv
`timescale 1ns/1ps
module dbr_read_stage #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          pipe,
   input  logic          fire,
   input  logic [DW-1:0] word,
   input  logic          drive_n,
   output logic [DW-1:0] dout,
   output logic          dout_vld
);
   import dbr_pkg::*;

   logic [DW-1:0] s1_d, s2_d, pick_d;
   logic          s1_v, s2_v, pick_v;
   rd_lat_e       lat;

   assign lat = rd_lat_e'(pipe);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
      end else begin
         s1_v <= fire;
         s2_v <= s1_v;
      end
   end

   always_ff @(posedge clk) begin
      s1_d <= word;
      s2_d <= s1_d;
   end

   always_comb begin
      if (lat == LAT_LONG) begin
         pick_d = s2_d;
         pick_v = s2_v;
      end else begin
         pick_d = s1_d;
         pick_v = s1_v;
      end
   end

   assign dout_vld = pick_v && !drive_n;
   assign dout     = dout_vld ? pick_d : '0;

   p_short_latency_r8: assert property (@(posedge clk) disable iff (!arst_n)
      (fire && !pipe) |=> (pipe || drive_n || dout_vld));
   p_long_latency_r9: assert property (@(posedge clk) disable iff (!arst_n)
      (fire && pipe) |=> (!pipe || !dout_vld || $past(s1_v)));
   p_gate_r10: assert property (@(posedge clk) disable iff (!arst_n)
      drive_n |-> (!dout_vld && dout == '0));
endmodule

// File: rtl/dbr_shared_array.sv
`timescale 1ns/1ps
module dbr_shared_array #(
   parameter int AW = 10,
   parameter int DW = 9
) (
   input  logic          clk_l,
   input  logic          clk_r,
   input  logic          arst_n,
   input  logic          we_l,
   input  logic [AW-1:0] wa_l,
   input  logic [DW-1:0] wd_l,
   input  logic          we_r,
   input  logic [AW-1:0] wa_r,
   input  logic [DW-1:0] wd_r,
   input  logic [AW-1:0] ra_l,
   input  logic [AW-1:0] ra_r,
   output logic [DW-1:0] rq_l,
   output logic [DW-1:0] rq_r
);
   localparam int DEPTH = 1 << AW;

   // one bank per writer; owner of a word = tag_l ^ tag_r (1 = left bank)
   logic [DW-1:0]    bank_l [DEPTH];
   logic [DW-1:0]    bank_r [DEPTH];
   logic [DEPTH-1:0] tag_l, tag_r;
   logic             clash;

   assign clash = we_l && we_r && (wa_l == wa_r);

   always_ff @(posedge clk_l) begin
      if (we_l) bank_l[wa_l] <= wd_l;
   end

   always_ff @(posedge clk_r) begin
      if (we_r) bank_r[wa_r] <= wd_r;
   end

   always_ff @(posedge clk_l or negedge arst_n) begin
      if (!arst_n)   tag_l <= '0;
      else if (we_l) tag_l[wa_l] <= ~tag_r[wa_l];
   end

   // left wins a same-edge clash: right leaves ownership untouched
   always_ff @(posedge clk_r or negedge arst_n) begin
      if (!arst_n)              tag_r <= '0;
      else if (we_r && !clash)  tag_r[wa_r] <= tag_l[wa_r];
   end

   assign rq_l = (tag_l[ra_l] ^ tag_r[ra_l]) ? bank_l[ra_l] : bank_r[ra_l];
   assign rq_r = (tag_l[ra_r] ^ tag_r[ra_r]) ? bank_l[ra_r] : bank_r[ra_r];
endmodule

// File: rtl/dual_burst_ram.sv
`timescale 1ns/1ps
module dual_burst_ram #(
   parameter int AW = 10,
   parameter int DW = 9
) (
   input  logic          arst_n,
   input  logic          l_clk,
   input  logic          l_sel0_n,
   input  logic          l_sel1,
   input  logic          l_wr_n,
   input  logic          l_drive_n,
   input  logic          l_strobe_n,
   input  logic          l_step_n,
   input  logic          l_zero_n,
   input  logic          l_pipe,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_din,
   output logic [DW-1:0] l_dout,
   output logic          l_dout_vld,
   input  logic          r_clk,
   input  logic          r_sel0_n,
   input  logic          r_sel1,
   input  logic          r_wr_n,
   input  logic          r_drive_n,
   input  logic          r_strobe_n,
   input  logic          r_step_n,
   input  logic          r_zero_n,
   input  logic          r_pipe,
   input  logic [AW-1:0] r_addr,
   input  logic [DW-1:0] r_din,
   output logic [DW-1:0] r_dout,
   output logic          r_dout_vld
);
   import dbr_pkg::*;

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("dual_burst_ram: AW must lie in 1..16");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dual_burst_ram: DW must be at least 1");
   end

   logic          p_clk     [NUM_PORTS];
   logic          p_sel0_n  [NUM_PORTS];
   logic          p_sel1    [NUM_PORTS];
   logic          p_wr_n    [NUM_PORTS];
   logic          p_drive_n [NUM_PORTS];
   logic          p_strobe_n[NUM_PORTS];
   logic          p_step_n  [NUM_PORTS];
   logic          p_zero_n  [NUM_PORTS];
   logic          p_pipe    [NUM_PORTS];
   logic [AW-1:0] p_addr    [NUM_PORTS];
   logic [DW-1:0] p_din     [NUM_PORTS];
   logic [DW-1:0] p_dout    [NUM_PORTS];
   logic          p_vld     [NUM_PORTS];
   logic [AW-1:0] p_acc     [NUM_PORTS];
   logic [DW-1:0] p_rword   [NUM_PORTS];
   logic          p_we      [NUM_PORTS];
   logic          p_re      [NUM_PORTS];

   assign p_clk[LEFT]      = l_clk;      assign p_clk[RIGHT]      = r_clk;
   assign p_sel0_n[LEFT]   = l_sel0_n;   assign p_sel0_n[RIGHT]   = r_sel0_n;
   assign p_sel1[LEFT]     = l_sel1;     assign p_sel1[RIGHT]     = r_sel1;
   assign p_wr_n[LEFT]     = l_wr_n;     assign p_wr_n[RIGHT]     = r_wr_n;
   assign p_drive_n[LEFT]  = l_drive_n;  assign p_drive_n[RIGHT]  = r_drive_n;
   assign p_strobe_n[LEFT] = l_strobe_n; assign p_strobe_n[RIGHT] = r_strobe_n;
   assign p_step_n[LEFT]   = l_step_n;   assign p_step_n[RIGHT]   = r_step_n;
   assign p_zero_n[LEFT]   = l_zero_n;   assign p_zero_n[RIGHT]   = r_zero_n;
   assign p_pipe[LEFT]     = l_pipe;     assign p_pipe[RIGHT]     = r_pipe;
   assign p_addr[LEFT]     = l_addr;     assign p_addr[RIGHT]     = r_addr;
   assign p_din[LEFT]      = l_din;      assign p_din[RIGHT]      = r_din;

   assign l_dout = p_dout[LEFT];   assign l_dout_vld = p_vld[LEFT];
   assign r_dout = p_dout[RIGHT];  assign r_dout_vld = p_vld[RIGHT];

   for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      logic act;
      assign act      = port_active(p_sel0_n[gp], p_sel1[gp]);
      assign p_we[gp] = act && !p_wr_n[gp];
      assign p_re[gp] = act &&  p_wr_n[gp];

      dbr_burst_ctr #(.AW(AW)) u_ctr (
         .clk      (p_clk[gp]),
         .arst_n   (arst_n),
         .ext_addr (p_addr[gp]),
         .strobe_n (p_strobe_n[gp]),
         .step_n   (p_step_n[gp]),
         .zero_n   (p_zero_n[gp]),
         .acc_addr (p_acc[gp])
      );

      dbr_read_stage #(.DW(DW)) u_rd (
         .clk      (p_clk[gp]),
         .arst_n   (arst_n),
         .pipe     (p_pipe[gp]),
         .fire     (p_re[gp]),
         .word     (p_rword[gp]),
         .drive_n  (p_drive_n[gp]),
         .dout     (p_dout[gp]),
         .dout_vld (p_vld[gp])
      );

      p_idle_port_r1: assert property (@(posedge p_clk[gp]) disable iff (!arst_n)
         (!act && !$past(act) && !$past(act, 2)) |-> !p_vld[gp]);
   end

   dbr_shared_array #(.AW(AW), .DW(DW)) u_arr (
      .clk_l  (l_clk),
      .clk_r  (r_clk),
      .arst_n (arst_n),
      .we_l   (p_we[LEFT]),
      .wa_l   (p_acc[LEFT]),
      .wd_l   (l_din),
      .we_r   (p_we[RIGHT]),
      .wa_r   (p_acc[RIGHT]),
      .wd_r   (r_din),
      .ra_l   (p_acc[LEFT]),
      .ra_r   (p_acc[RIGHT]),
      .rq_l   (p_rword[LEFT]),
      .rq_r   (p_rword[RIGHT])
   );
endmodule

// File: tb/dual_burst_ram_tb_top.sv
`timescale 1ns/1ps
module dual_burst_ram_tb_top;
   localparam int AW = 10;
   localparam int DW = 9;

   typedef struct {
      int            due;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic s0n[2], s1[2], wrn[2], oen[2], stn[2], spn[2], zn[2], pm[2];
   logic [AW-1:0] ad[2];
   logic [DW-1:0] di[2];
   logic [DW-1:0] dq[2];
   logic          dv[2];

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit started = 0;
   bit done = 0;
   logic [AW-1:0] mcnt[2];
   logic [DW-1:0] mem[1 << AW];
   exp_t q_l[$];
   exp_t q_r[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_burst_ram #(.AW(AW), .DW(DW)) dut_i (
      .arst_n(arst_n),
      .l_clk(clk), .l_sel0_n(s0n[0]), .l_sel1(s1[0]), .l_wr_n(wrn[0]),
      .l_drive_n(oen[0]), .l_strobe_n(stn[0]), .l_step_n(spn[0]),
      .l_zero_n(zn[0]), .l_pipe(pm[0]), .l_addr(ad[0]), .l_din(di[0]),
      .l_dout(dq[0]), .l_dout_vld(dv[0]),
      .r_clk(clk), .r_sel0_n(s0n[1]), .r_sel1(s1[1]), .r_wr_n(wrn[1]),
      .r_drive_n(oen[1]), .r_strobe_n(stn[1]), .r_step_n(spn[1]),
      .r_zero_n(zn[1]), .r_pipe(pm[1]), .r_addr(ad[1]), .r_din(di[1]),
      .r_dout(dq[1]), .r_dout_vld(dv[1])
   );

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 37 + 11) & 'h1FF);
   endfunction

   task automatic push(input int p, input exp_t e);
      if (p == 0) q_l.push_back(e);
      else        q_r.push_back(e);
   endtask

   // ce[0] drives sel0_n, ce[1] drives sel1; active only for 2'b10
   task automatic cmd(input int p, input logic [1:0] ce, input bit wr, input bit st,
                      input bit sp, input bit z, input int a, input int d, input string tag);
      logic [AW-1:0] ea;
      exp_t e;
      s0n[p] = ce[0]; s1[p] = ce[1]; wrn[p] = !wr;
      stn[p] = !st; spn[p] = !sp; zn[p] = !z;
      ad[p] = AW'(a); di[p] = DW'(d);
      if (z)       ea = '0;
      else if (st) ea = AW'(a);
      else if (sp) ea = mcnt[p] + AW'(1);
      else         ea = mcnt[p];
      mcnt[p] = ea;
      if (ce == 2'b10) begin
         if (wr) mem[ea] = DW'(d);
         else begin
            e.due = cyc + 1 + (pm[p] ? 1 : 0);
            e.data = mem[ea];
            e.tag = tag;
            push(p, e);
         end
      end
   endtask

   task automatic idle(input int p);
      cmd(p, 2'b01, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic one(input int p, input logic [1:0] ce, input bit wr, input bit st,
                      input bit sp, input bit z, input int a, input int d, input string tag);
      cmd(p, ce, wr, st, sp, z, a, d, tag);
      idle(1 - p);
      tick();
   endtask

   task automatic flush(input int n);
      for (int i = 0; i < n; i++) begin
         idle(0); idle(1); tick();
      end
   endtask

   // monitor: per port, every cycle, compare against the scoreboard head
   always @(negedge clk) begin
      if (started && !done) begin
         for (int p = 0; p < 2; p++) begin
            bit due;
            exp_t e;
            logic          xv;
            logic [DW-1:0] xd;
            string         tg;
            due = 0;
            e.due = 0; e.data = '0; e.tag = "";
            if (p == 0 && q_l.size() > 0 && q_l[0].due == cyc) begin due = 1; e = q_l.pop_front(); end
            if (p == 1 && q_r.size() > 0 && q_r[0].due == cyc) begin due = 1; e = q_r.pop_front(); end
            xv = due && !oen[p];
            xd = xv ? e.data : '0;
            tg = due ? (oen[p] ? {e.tag, " R10"} : e.tag) : "R1 R8 R9 idle";
            checks++;
            if (dv[p] !== xv || dq[p] !== xd) begin
               errors++;
               $display("FAIL %s port %0d cyc %0d: vld=%b dout=%h expected vld=%b dout=%h",
                        tg, p, cyc, dv[p], dq[p], xv, xd);
            end
         end
      end
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) begin
         mcnt[p] = '0; pm[p] = 1'b0; oen[p] = 1'b0;
         s0n[p] = 1'b1; s1[p] = 1'b0; wrn[p] = 1'b1;
         stn[p] = 1'b1; spn[p] = 1'b1; zn[p] = 1'b1;
         ad[p] = '0; di[p] = '0;
      end
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      #18 arst_n = 1'b1;
      @(negedge clk);
      // R13: outputs quiet after reset
      for (int p = 0; p < 2; p++) begin
         checks++;
         if (dv[p] !== 1'b0 || dq[p] !== '0) begin
            errors++;
            $display("FAIL R13 port %0d: vld=%b dout=%h expected vld=0 dout=0", p, dv[p], dq[p]);
         end
      end
      started = 1;
      tick();

      // R2 R3: left fills a region, plus the top word
      for (int a = 0; a <= 12; a++) one(0, 2'b10, 1, 1, 0, 0, a, pat(a), "R2");
      one(0, 2'b10, 1, 1, 0, 0, 1023, pat(1023), "R2");

      // R12 R3 R4: right burst in short mode (R8)
      one(1, 2'b10, 0, 1, 0, 0, 5, 0, "R3 R8 R12 load");
      for (int k = 0; k < 4; k++) one(1, 2'b10, 0, 0, 1, 0, 0, 0, "R4 R12 step");
      one(1, 2'b10, 0, 0, 0, 0, 0, 0, "R7 hold");
      // R5: load with step also low -> address 2, not 3
      one(1, 2'b10, 0, 1, 1, 0, 2, 0, "R5 load beats step");
      one(1, 2'b10, 0, 0, 1, 0, 0, 0, "R4 after R5");
      // R6: clear beats load and step
      one(1, 2'b10, 0, 1, 1, 1, 11, 0, "R6 clear wins");
      one(1, 2'b10, 0, 0, 1, 0, 0, 0, "R6 step from zero");
      one(1, 2'b10, 0, 0, 1, 1, 0, 0, "R5 R6 step masked by clear");
      // R4 wrap
      one(1, 2'b10, 0, 1, 0, 0, 1023, 0, "R4 top");
      one(1, 2'b10, 0, 0, 1, 0, 0, 0, "R4 wrap");
      flush(3);

      // R9: long latency on left, back-to-back
      pm[0] = 1'b1;
      one(0, 2'b10, 0, 1, 0, 0, 8, 0, "R9 load");
      one(0, 2'b10, 0, 0, 0, 0, 0, 0, "R7 R9 hold");
      one(0, 2'b10, 0, 0, 1, 0, 0, 0, "R9 step");
      flush(3);
      pm[0] = 1'b0;
      one(0, 2'b10, 0, 1, 0, 0, 4, 0, "R8 short");
      flush(2);

      // R1: deselected writes and reads
      one(0, 2'b11, 1, 1, 0, 0, 6, 'h1FF, "R1");
      one(0, 2'b00, 1, 1, 0, 0, 7, 'h1FF, "R1");
      one(0, 2'b01, 0, 1, 0, 0, 3, 0, "R1");
      one(0, 2'b10, 0, 1, 0, 0, 6, 0, "R1 readback");
      one(0, 2'b10, 0, 1, 0, 0, 7, 0, "R1 readback");
      flush(2);

      // R10: drive enable withdrawn during a due read
      oen[1] = 1'b1;
      one(1, 2'b10, 0, 1, 0, 0, 5, 0, "R10");
      pm[1] = 1'b1;
      flush(2);
      one(1, 2'b10, 0, 1, 0, 0, 9, 0, "R9 R10");
      flush(3);
      oen[1] = 1'b0;
      pm[1] = 1'b0;
      flush(1);

      // R11: same-edge writes to one address
      cmd(1, 2'b10, 1, 1, 0, 0, 20, 'h0AA, "R11");
      cmd(0, 2'b10, 1, 1, 0, 0, 20, 'h155, "R11");
      tick();
      one(0, 2'b10, 0, 1, 0, 0, 20, 0, "R11 left read");
      one(1, 2'b10, 0, 1, 0, 0, 20, 0, "R11 right read");
      // R12: right writes, left reads; then right rewrites word 20
      one(1, 2'b10, 1, 1, 0, 0, 30, 'h0C3, "R12");
      one(0, 2'b10, 0, 1, 0, 0, 30, 0, "R12");
      one(1, 2'b10, 1, 1, 0, 0, 20, 'h033, "R12");
      one(0, 2'b10, 0, 1, 0, 0, 20, 0, "R12 R11 later owner");
      flush(4);

      checks++;
      if (q_l.size() != 0 || q_r.size() != 0) begin
         errors++;
         $display("FAIL R8 R9: pending reads %0d/%0d expected 0/0", q_l.size(), q_r.size());
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule